// File: doc/BRIEF.md
# Code Readback Scrambler and Protection Gate

This block sits on the read path of on-chip program memory. It serves two kinds of access. The first is a test-mode readback: the block takes an address and the raw code byte stored there. It XNORs that byte with one entry of a 32-entry key table and returns the result one cycle later. When the strongest protection level is active, the readback is suppressed. The key table comes out of reset with every bit set, so an untouched table passes code through unchanged. A small write port loads the key entries.

The second kind of access is a table-read instruction that wants to fetch a byte from internal code space. The block decides whether that read is allowed. Two fuse inputs select the protection level. Once any protection is active, a table read issued by code that runs from external memory may not reach internal code. Whether code counts as external depends on the external-access pin. That pin is captured while reset is held and frozen afterwards, so later toggling of the pin cannot open a path into internal code.

Top module: `code_guard`

## Requirements
- R1: While `rst` is high, every key entry returns to 8'hFF and `vfy_valid` is 0. After reset, a readback with untouched keys returns the code byte unchanged.
- R2: A readback result appears on `vfy_valid`/`vfy_data` exactly one clock edge after `vfy_req` is sampled high. `vfy_valid` is 0 in any cycle whose previous edge sampled `vfy_req` low.
- R3: When the level is not sealed, `vfy_data` = ~(`vfy_code` ^ key[`vfy_addr[4:0]`]). The address bits above bit 4 do not affect the result.
- R4: When `key_we` is high, `key_wdata` is stored in entry `key_widx` at the clock edge. A readback sampled on that same edge uses the entry's previous content.
- R5: A code byte of 8'hFF reads back as the selected key entry itself.
- R6: Level encoding (1 = fuse blown): `fuse_a`=0 gives open, whatever `fuse_b` is; `fuse_a`=1 with `fuse_b`=0 gives no-external-read; both at 1 gives sealed. When sealed, a readback returns 8'hFF.
- R7: `ea_held` copies `ea_pin` at each edge while `rst` is high. With `rst` low it keeps its value.
- R8: Let code count as running externally when `ea_held`=0 or `exec_pc` > 16'h1FFF. Let the target count as internal when `tbl_addr` <= 16'h1FFF. Then `tbl_permit` is 0 exactly when `fuse_a`=1, code runs externally and the target is internal. In every other case it is 1. The output is combinational in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_we | input | 1 | Key entry write strobe |
| key_widx | input | 5 | Key entry index to write |
| key_wdata | input | 8 | Key entry value |
| vfy_req | input | 1 | Readback request |
| vfy_addr | input | 16 | Readback address |
| vfy_code | input | 8 | Raw code byte at that address |
| vfy_valid | output | 1 | Readback result valid |
| vfy_data | output | 8 | Scrambled or suppressed readback byte |
| fuse_a | input | 1 | First protection fuse (1 = blown) |
| fuse_b | input | 1 | Second protection fuse (1 = blown) |
| ea_pin | input | 1 | External-access pin level (1 = internal code enabled) |
| exec_pc | input | 16 | Address of the executing table-read instruction |
| tbl_addr | input | 16 | Code address the table read targets |
| ea_held | output | 1 | Pin level captured during reset |
| tbl_permit | output | 1 | Table read into internal code allowed |

## Verification
A readback result is due one edge after its request. The driver task therefore drives requests at the falling edge and pushes the expected byte at that moment, using the key model as it stood before any write on the same edge. The monitor pops and compares at the next falling edge, and it flags any valid result that arrives with nothing queued. The permit output is combinational, and the captured pin changes only at an edge under reset. These two are sampled one time unit after the inputs are driven at a falling edge. Each case is checked against a formula written from R8, with the fuses, the captured pin and the two addresses set to hit every term.

// File: rtl/code_guard_pkg.sv
package code_guard_pkg;

    typedef enum logic [1:0] {
        GUARD_OPEN     = 2'd0,
        GUARD_NO_XREAD = 2'd1,
        GUARD_SEALED   = 2'd2
    } guard_lvl_e;

    typedef struct packed {
        logic xread_block;
        logic verify_block;
    } guard_ctl_t;

    // Level from the two fuses; the second fuse counts only with the first.
    function automatic guard_lvl_e lvl_from_fuses(input logic fa, input logic fb);
        guard_lvl_e l;
        if (!fa)      l = GUARD_OPEN;
        else if (!fb) l = GUARD_NO_XREAD;
        else          l = GUARD_SEALED;
        return l;
    endfunction

    function automatic guard_ctl_t ctl_from_lvl(input guard_lvl_e l);
        guard_ctl_t c;
        c.xread_block  = (l != GUARD_OPEN);
        c.verify_block = (l == GUARD_SEALED);
        return c;
    endfunction

endpackage

// File: rtl/cg_key_store.sv
module cg_key_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] entry [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                entry[g] <= '1;
            else if (wr_en && (wr_idx == IDX_W'(g)))
                entry[g] <= wr_data;
        end
    end

    assign rd_data = entry[rd_idx];

endmodule

// File: rtl/cg_lock_decode.sv
module cg_lock_decode
    import code_guard_pkg::*;
(
    input  logic       fuse_a,
    input  logic       fuse_b,
    output guard_lvl_e lvl,
    output guard_ctl_t ctl
);

    always_comb begin
        lvl = lvl_from_fuses(fuse_a, fuse_b);
        ctl = ctl_from_lvl(lvl);
    end

endmodule

// File: rtl/cg_verify_path.sv
module cg_verify_path #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [DATA_W-1:0] code,
    input  logic [DATA_W-1:0] key_byte,
    input  logic              seal,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o
);

    logic [DATA_W-1:0] scrambled;

    always_comb begin
        scrambled = seal ? {DATA_W{1'b1}} : ~(code ^ key_byte);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            data_o  <= '1;
        end else begin
            valid_o <= req;
            if (req)
                data_o <= scrambled;
        end
    end

endmodule

// File: rtl/cg_fetch_gate.sv
module cg_fetch_gate #(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] INT_LAST = 16'h1FFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ea_pin,
    input  logic              xread_block,
    input  logic [ADDR_W-1:0] exec_pc,
    input  logic [ADDR_W-1:0] tbl_addr,
    output logic              ea_held,
    output logic              permit
);

    logic runs_ext;
    logic hits_int;

    always_ff @(posedge clk) begin
        if (rst)
            ea_held <= ea_pin;
    end

    always_comb begin
        runs_ext = !ea_held || (exec_pc > INT_LAST);
        hits_int = (tbl_addr <= INT_LAST);
        permit   = !(xread_block && runs_ext && hits_int);
    end

endmodule

// File: rtl/code_guard.sv
module code_guard
    import code_guard_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 16,
    parameter int KEY_DEPTH = 32,
    parameter logic [ADDR_W-1:0] INT_LAST = 16'h1FFF,
    localparam int IDX_W    = $clog2(KEY_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              key_we,
    input  logic [IDX_W-1:0]  key_widx,
    input  logic [DATA_W-1:0] key_wdata,
    input  logic              vfy_req,
    input  logic [ADDR_W-1:0] vfy_addr,
    input  logic [DATA_W-1:0] vfy_code,
    output logic              vfy_valid,
    output logic [DATA_W-1:0] vfy_data,
    input  logic              fuse_a,
    input  logic              fuse_b,
    input  logic              ea_pin,
    input  logic [ADDR_W-1:0] exec_pc,
    input  logic [ADDR_W-1:0] tbl_addr,
    output logic              ea_held,
    output logic              tbl_permit
);

    guard_lvl_e        lvl;
    guard_ctl_t        ctl;
    logic [DATA_W-1:0] key_rd;
    logic [IDX_W-1:0]  key_sel;
    logic              unused_hi_addr;

    assign key_sel        = vfy_addr[IDX_W-1:0];
    assign unused_hi_addr = ^vfy_addr[ADDR_W-1:IDX_W];

    cg_lock_decode u_lock (
        .fuse_a (fuse_a),
        .fuse_b (fuse_b),
        .lvl    (lvl),
        .ctl    (ctl)
    );

    cg_key_store #(.DATA_W(DATA_W), .DEPTH(KEY_DEPTH)) u_keys (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (key_we),
        .wr_idx  (key_widx),
        .wr_data (key_wdata),
        .rd_idx  (key_sel),
        .rd_data (key_rd)
    );

    cg_verify_path #(.DATA_W(DATA_W)) u_vfy (
        .clk      (clk),
        .rst      (rst),
        .req      (vfy_req),
        .code     (vfy_code),
        .key_byte (key_rd),
        .seal     (ctl.verify_block),
        .valid_o  (vfy_valid),
        .data_o   (vfy_data)
    );

    cg_fetch_gate #(.ADDR_W(ADDR_W), .INT_LAST(INT_LAST)) u_gate (
        .clk         (clk),
        .rst         (rst),
        .ea_pin      (ea_pin),
        .xread_block (ctl.xread_block),
        .exec_pc     (exec_pc),
        .tbl_addr    (tbl_addr),
        .ea_held     (ea_held),
        .permit      (tbl_permit)
    );

endmodule

// File: rtl/code_guard_chk.sv
module code_guard_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              vfy_req,
    input logic [DATA_W-1:0] vfy_code,
    input logic [DATA_W-1:0] key_rd,
    input logic              vfy_valid,
    input logic [DATA_W-1:0] vfy_data,
    input logic              fuse_a,
    input logic              fuse_b,
    input logic              ea_held,
    input logic              tbl_permit
);

    // R1
    a_r1_reset_idle: assert property (@(posedge clk) rst |=> !vfy_valid);

    // R2
    a_r2_result_due: assert property (@(posedge clk) disable iff (rst)
        vfy_req |=> vfy_valid);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !vfy_req |=> !vfy_valid);

    // R3
    a_r3_scramble: assert property (@(posedge clk) disable iff (rst)
        (vfy_req && !(fuse_a && fuse_b)) |=>
            vfy_data == ~($past(vfy_code) ^ $past(key_rd)));

    // R6
    a_r6_sealed_ones: assert property (@(posedge clk) disable iff (rst)
        (vfy_req && fuse_a && fuse_b) |=> vfy_data == {DATA_W{1'b1}});

    // R7
    a_r7_pin_frozen: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(ea_held));

    // R8
    a_r8_open_permits: assert property (@(posedge clk) disable iff (rst)
        !fuse_a |-> tbl_permit);

endmodule

bind code_guard code_guard_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .vfy_req    (vfy_req),
    .vfy_code   (vfy_code),
    .key_rd     (key_rd),
    .vfy_valid  (vfy_valid),
    .vfy_data   (vfy_data),
    .fuse_a     (fuse_a),
    .fuse_b     (fuse_b),
    .ea_held    (ea_held),
    .tbl_permit (tbl_permit)
);

// File: tb/sim_code_guard.sv
module sim_code_guard;

    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] LAST = 16'h1FFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        key_we = 1'b0;
    logic [4:0]  key_widx = '0;
    logic [7:0]  key_wdata = '0;
    logic        vfy_req = 1'b0;
    logic [15:0] vfy_addr = '0;
    logic [7:0]  vfy_code = '0;
    logic        vfy_valid;
    logic [7:0]  vfy_data;
    logic        fuse_a = 1'b0;
    logic        fuse_b = 1'b0;
    logic        ea_pin = 1'b0;
    logic [15:0] exec_pc = '0;
    logic [15:0] tbl_addr = '0;
    logic        ea_held;
    logic        tbl_permit;

    int checks = 0;
    int bad = 0;
    bit done = 0;

    logic [7:0] key_m [32];
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    code_guard u0 (
        .clk(clk), .rst(rst),
        .key_we(key_we), .key_widx(key_widx), .key_wdata(key_wdata),
        .vfy_req(vfy_req), .vfy_addr(vfy_addr), .vfy_code(vfy_code),
        .vfy_valid(vfy_valid), .vfy_data(vfy_data),
        .fuse_a(fuse_a), .fuse_b(fuse_b), .ea_pin(ea_pin),
        .exec_pc(exec_pc), .tbl_addr(tbl_addr),
        .ea_held(ea_held), .tbl_permit(tbl_permit)
    );

    function automatic logic [7:0] expect_vfy(logic [15:0] a, logic [7:0] c);
        if (fuse_a && fuse_b) return 8'hFF;          // R6
        return ~(c ^ key_m[a[4:0]]);                 // R3
    endfunction

    function automatic logic expect_permit(logic [15:0] pc, logic [15:0] ta);
        logic ext;
        ext = !ea_held || (pc > LAST);
        return !(fuse_a && ext && (ta <= LAST));     // R8
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reset_keys_model();
        for (int i = 0; i < 32; i++) key_m[i] = 8'hFF;
    endtask

    // Driver: readback request for one cycle, expected item queued.
    task automatic drive_vfy(string req, logic [15:0] a, logic [7:0] c);
        vfy_req  = 1'b1;
        vfy_addr = a;
        vfy_code = c;
        exp_q.push_back(expect_vfy(a, c));
        tag_q.push_back(req);
        @(negedge clk);
        vfy_req = 1'b0;
    endtask

    task automatic write_key(logic [4:0] idx, logic [7:0] d);
        key_we = 1'b1; key_widx = idx; key_wdata = d;
        @(negedge clk);
        key_we = 1'b0;
        key_m[idx] = d;
    endtask

    // R4: write and readback of the same entry on the same edge.
    task automatic write_and_vfy(logic [4:0] idx, logic [7:0] d, logic [7:0] c);
        key_we = 1'b1; key_widx = idx; key_wdata = d;
        vfy_req = 1'b1; vfy_addr = {11'h0, idx}; vfy_code = c;
        exp_q.push_back(expect_vfy({11'h0, idx}, c));
        tag_q.push_back("R4");
        @(negedge clk);
        key_we = 1'b0; vfy_req = 1'b0;
        key_m[idx] = d;
    endtask

    task automatic chk_permit(string req, logic [15:0] pc, logic [15:0] ta);
        exec_pc = pc; tbl_addr = ta;
        #1;
        check(req, {15'h0, tbl_permit}, {15'h0, expect_permit(pc, ta)});
        @(negedge clk);
    endtask

    // Monitor: compare results as they appear.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && vfy_valid) begin
                if (exp_q.size() == 0) begin
                    check("R2", {15'h0, vfy_valid}, 16'h0);
                end else begin
                    automatic logic [7:0] e = exp_q.pop_front();
                    automatic string t = tag_q.pop_front();
                    check(t, {8'h0, vfy_data}, {8'h0, e});
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        reset_keys_model();
        ea_pin = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", {15'h0, vfy_valid}, 16'h0);
        check("R7", {15'h0, ea_held}, 16'h0);
        rst = 1'b0;
        @(negedge clk);

        // R1/R3: untouched keys pass code through
        drive_vfy("R1", 16'h0000, 8'h12);
        drive_vfy("R3", 16'h0001, 8'hA5);
        drive_vfy("R3", 16'h0002, 8'h00);
        @(negedge clk);
        check("R2", {15'h0, vfy_valid}, 16'h0);

        // R3: programmed key, upper address bits ignored
        write_key(5'd5, 8'h3C);
        write_key(5'd31, 8'h81);
        drive_vfy("R3", 16'h0025, 8'hA5);
        drive_vfy("R3", 16'h1FE5, 8'hA5);
        drive_vfy("R3", 16'hFFFF, 8'h7E);
        // R5: all-ones code returns the key byte
        drive_vfy("R5", 16'h0005, 8'hFF);
        drive_vfy("R5", 16'h003F, 8'hFF);
        // R4: same-edge write uses old key, then the new one
        write_and_vfy(5'd9, 8'h55, 8'h0F);
        drive_vfy("R4", 16'h0009, 8'h0F);

        // R6: fuse combinations
        fuse_a = 1'b0; fuse_b = 1'b1;
        drive_vfy("R6", 16'h0005, 8'h11);
        fuse_a = 1'b1; fuse_b = 1'b0;
        drive_vfy("R6", 16'h0005, 8'h11);
        fuse_a = 1'b1; fuse_b = 1'b1;
        drive_vfy("R6", 16'h0005, 8'h11);
        drive_vfy("R6", 16'h0000, 8'h00);
        @(negedge clk);

        // R7: pin changes after reset are ignored
        ea_pin = 1'b1;
        @(negedge clk); #1;
        check("R7", {15'h0, ea_held}, 16'h0);
        @(negedge clk);

        // R8 with captured pin low: external execution everywhere
        fuse_a = 1'b1; fuse_b = 1'b0;
        chk_permit("R8", 16'h0100, 16'h0200);
        chk_permit("R8", 16'h0100, 16'h2000);
        fuse_a = 1'b0; fuse_b = 1'b1;
        chk_permit("R8", 16'h0100, 16'h0200);

        // second reset captures pin high, keys return to all ones
        rst = 1'b1;
        repeat (2) @(negedge clk); #1;
        check("R7", {15'h0, ea_held}, 16'h1);
        check("R1", {15'h0, vfy_valid}, 16'h0);
        rst = 1'b0;
        reset_keys_model();
        ea_pin = 1'b0;
        @(negedge clk); #1;
        check("R7", {15'h0, ea_held}, 16'h1);
        @(negedge clk);
        fuse_a = 1'b0; fuse_b = 1'b0;
        drive_vfy("R1", 16'h0005, 8'h5A);

        // R8 with captured pin high
        fuse_a = 1'b1; fuse_b = 1'b1;
        chk_permit("R8", 16'h0100, 16'h0200);
        chk_permit("R8", 16'h2000, 16'h0200);
        chk_permit("R8", 16'h2000, 16'h2000);
        chk_permit("R8", 16'h1FFF, 16'h1FFF);
        fuse_a = 1'b1; fuse_b = 1'b0;
        chk_permit("R8", 16'hE000, 16'h1FFF);
        fuse_a = 1'b0;
        chk_permit("R8", 16'hE000, 16'h0000);

        repeat (3) @(negedge clk);
        check("R2", exp_q.size(), 16'h0);
        done = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule